// File: doc/BRIEF.md
# Receive Line Status Tracker

This block holds the line status byte of a serial port. It takes single-cycle events from the receiver, the transmitter and the CPU bus, and keeps six sticky flags from them: data ready, overrun, parity error, framing error, break and transmit-holding empty. Some flags clear when the CPU takes the received character out of the buffer. The others clear when the CPU reads the status byte. When a set event and a clear arrive in the same cycle, one fixed rule decides which wins.

The block has its own break detector. It counts 16x sample ticks for as long as the receive line stays low. It compares the count against the length of one frame. That length comes from the configured word length, the parity enable and the stop-bit count. In the alternate modem receive mode, the line must stay low for two frame times before a break is reported. Framing errors are never reported in that mode, because stop bits are restored before the characters reach this block. The status byte is registered, so every event shows up one cycle after the clock edge that captures it.

Top module: `rx_line_status`

## Requirements
- R1: Bit 0 (data ready) sets one cycle after `rx_char_done`. It clears after `cpu_rbr_rd`, or after `cpu_rbr_wr` with `cpu_wdata` equal to 0. A buffer write with nonzero data leaves the bit unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R2: Bit 1 (overrun) sets when `rx_char_done` arrives while bit 0 is 1 and no `cpu_rbr_rd` happens in that cycle. A character that arrives in the same cycle as a buffer read does not cause an overrun.
- R3: Bit 2 (parity error) sets when `rx_char_done` arrives together with `rx_par_err`.
- R4: Bit 3 (framing error) sets when `rx_char_done` arrives together with `rx_frm_err` while `cfg_modem_mode` is 0. While `cfg_modem_mode` is 1, bit 3 never sets.
- R5: Bits 1 to 4 clear one cycle after `cpu_lsr_rd`. A set event for one of these bits in the same cycle keeps that bit at 1.
- R6: Bit 4 (break) sets when `rx_line` has been 0 for N ticks of `tick16` in a row. N = 16 × F, where F = 1 + (5 + `cfg_wlen`) + `cfg_par_en` + (1 + `cfg_stop2`). Any cycle with `rx_line` at 1 restarts the count. A single low period raises break only once.
- R7: With `cfg_modem_mode` at 1, the break threshold is 2 × N ticks.
- R8: Bit 5 (transmit-holding empty) sets after `tx_empty_evt` and clears after `cpu_thr_wr`. If both arrive in the same cycle, the write wins and the bit goes to 0.
- R9: After reset `lsr` reads 0x20. Bits 7 and 6 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wlen | input | 2 | Word length code: 0 to 3 selects 5 to 8 data bits |
| cfg_par_en | input | 1 | Parity bit present in the frame |
| cfg_stop2 | input | 1 | Two stop bits instead of one |
| cfg_modem_mode | input | 1 | Alternate modem receive mode: break needs two frames, framing errors are suppressed |
| rx_char_done | input | 1 | A character has been moved into the receive buffer |
| rx_par_err | input | 1 | That character had bad parity |
| rx_frm_err | input | 1 | That character lacked a valid stop bit |
| rx_line | input | 1 | Receive line level, 0 = space |
| tick16 | input | 1 | 16x bit-rate sample tick |
| tx_empty_evt | input | 1 | The transmitter has taken the holding register's contents |
| cpu_rbr_rd | input | 1 | CPU reads the receive buffer |
| cpu_rbr_wr | input | 1 | CPU writes the receive buffer |
| cpu_thr_wr | input | 1 | CPU loads the transmit holding register |
| cpu_lsr_rd | input | 1 | CPU reads the status byte |
| cpu_wdata | input | 8 | CPU write data |
| lsr | output | 8 | Line status byte |

## Verification
The hardest condition to create from the ports is the break threshold's exact edge. It is the point where one more tick of continuous space turns the flag on. That point moves with each of the sixteen frame shapes and doubles in modem mode. The bench holds `tick16` high every cycle while the line is low. It sweeps all thirty-two combinations and samples the flag after N−1 and after N ticks. It then clears the flag and runs a further N ticks on the same low period, to show that break does not fire a second time. Same-cycle collisions of set events with clears are each driven in a single cycle.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  // Bit positions in the status byte
  localparam int unsigned BIT_DR   = 0;
  localparam int unsigned BIT_OE   = 1;
  localparam int unsigned BIT_PE   = 2;
  localparam int unsigned BIT_FE   = 3;
  localparam int unsigned BIT_BI   = 4;
  localparam int unsigned BIT_THRE = 5;

  // Bit times in one frame: start + data + optional parity + stops
  function automatic int unsigned frame_bits(input logic [1:0] wlen,
                                             input logic par_en,
                                             input logic stop2);
    int unsigned n;
    n = 32'd7 + 32'(wlen) + 32'(par_en) + 32'(stop2);
    return n;
  endfunction

  // Ticks of continuous space needed to call a break
  function automatic int unsigned break_ticks(input int unsigned fbits,
                                              input int unsigned ovs,
                                              input logic modem);
    int unsigned frames;
    frames = modem ? 32'd2 : 32'd1;
    return fbits * ovs * frames;
  endfunction

endpackage

// File: rtl/lsr_flag.sv
module lsr_flag #(
  parameter logic RST_VAL  = 1'b0,
  parameter logic SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_nxt;

  generate
    if (SET_WINS) begin : g_set_wins
      always_comb q_nxt = set_i ? 1'b1 : (clr_i ? 1'b0 : q_o);
    end else begin : g_clr_wins
      always_comb q_nxt = clr_i ? 1'b0 : (set_i ? 1'b1 : q_o);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= q_nxt;
  end

endmodule

// File: rtl/lsr_break_det.sv
module lsr_break_det #(
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned MAX_FRAME  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_line,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_stop2,
  input  logic       cfg_modem_mode,
  output logic       brk_evt
);

  localparam int unsigned MAX_TICKS = MAX_FRAME * OVERSAMPLE * 2;
  localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit_m1;
  logic          fired;
  logic          space_tick;

  always_comb begin
    limit_m1 = CW'(lsr_pkg::break_ticks(
                 lsr_pkg::frame_bits(cfg_wlen, cfg_par_en, cfg_stop2),
                 OVERSAMPLE, cfg_modem_mode) - 32'd1);
  end

  assign space_tick = tick16 && !rx_line && !fired;
  assign brk_evt    = space_tick && (cnt >= limit_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (rx_line) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (space_tick) begin
      if (brk_evt) begin
        fired <= 1'b1;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_BRK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> !brk_evt) else $error("break fired twice"); // R6

  AST_BRK_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |-> !rx_line) else $error("break with line high"); // R6

endmodule

// File: rtl/rx_line_status.sv
module rx_line_status #(
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned MAX_FRAME  = 12,
  parameter int unsigned DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_wlen,
  input  logic          cfg_par_en,
  input  logic          cfg_stop2,
  input  logic          cfg_modem_mode,
  input  logic          rx_char_done,
  input  logic          rx_par_err,
  input  logic          rx_frm_err,
  input  logic          rx_line,
  input  logic          tick16,
  input  logic          tx_empty_evt,
  input  logic          cpu_rbr_rd,
  input  logic          cpu_rbr_wr,
  input  logic          cpu_thr_wr,
  input  logic          cpu_lsr_rd,
  input  logic [DW-1:0] cpu_wdata,
  output logic [7:0]    lsr
);

  localparam int unsigned NERR = 4;   // overrun, parity, framing, break

  // Named internal events
  logic            dr_q;
  logic            thre_q;
  logic            dr_clr;
  logic            brk_evt;
  logic            ovr_evt;
  logic            par_evt;
  logic            frm_evt;
  logic [NERR-1:0] err_set;
  logic [NERR-1:0] err_q;

  assign dr_clr  = cpu_rbr_rd || (cpu_rbr_wr && (cpu_wdata == '0));
  assign ovr_evt = rx_char_done && dr_q && !cpu_rbr_rd;
  assign par_evt = rx_char_done && rx_par_err;
  assign frm_evt = rx_char_done && rx_frm_err && !cfg_modem_mode;
  assign err_set = {brk_evt, frm_evt, par_evt, ovr_evt};

  lsr_break_det #(
    .OVERSAMPLE (OVERSAMPLE),
    .MAX_FRAME  (MAX_FRAME)
  ) u_brk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick16         (tick16),
    .rx_line        (rx_line),
    .cfg_wlen       (cfg_wlen),
    .cfg_par_en     (cfg_par_en),
    .cfg_stop2      (cfg_stop2),
    .cfg_modem_mode (cfg_modem_mode),
    .brk_evt        (brk_evt)
  );

  lsr_flag #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_dr (
    .clk (clk), .rst_n (rst_n), .set_i (rx_char_done), .clr_i (dr_clr), .q_o (dr_q)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NERR; gi++) begin : g_err
      lsr_flag #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_err (
        .clk (clk), .rst_n (rst_n), .set_i (err_set[gi]), .clr_i (cpu_lsr_rd), .q_o (err_q[gi])
      );
    end
  endgenerate

  lsr_flag #(.RST_VAL(1'b1), .SET_WINS(1'b0)) u_thre (
    .clk (clk), .rst_n (rst_n), .set_i (tx_empty_evt), .clr_i (cpu_thr_wr), .q_o (thre_q)
  );

  always_comb begin
    lsr                     = '0;
    lsr[lsr_pkg::BIT_DR]    = dr_q;
    lsr[lsr_pkg::BIT_OE]    = err_q[0];
    lsr[lsr_pkg::BIT_PE]    = err_q[1];
    lsr[lsr_pkg::BIT_FE]    = err_q[2];
    lsr[lsr_pkg::BIT_BI]    = err_q[3];
    lsr[lsr_pkg::BIT_THRE]  = thre_q;
  end

  AST_DR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_char_done |=> lsr[0]) else $error("data ready not set"); // R1

  AST_DR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rbr_rd && !rx_char_done) |=> !lsr[0]) else $error("data ready not cleared"); // R1

  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char_done && lsr[0] && !cpu_rbr_rd) |=> lsr[1]) else $error("overrun missed"); // R2

  AST_FE_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_modem_mode && !lsr[3]) |=> !lsr[3] || !$past(cfg_modem_mode))
    else $error("framing error in modem mode"); // R4

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_lsr_rd && !rx_char_done && !brk_evt) |=> (lsr[4:1] == 4'b0))
    else $error("status read did not clear"); // R5

  AST_THR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_thr_wr |=> !lsr[5]) else $error("holding empty after load"); // R8

  AST_THR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty_evt && !cpu_thr_wr) |=> lsr[5]) else $error("holding empty not set"); // R8

endmodule

// File: tb/rx_line_status_tb.sv
module rx_line_status_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_wlen = 2'd0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_stop2 = 1'b0;
  logic       cfg_modem_mode = 1'b0;
  logic       rx_char_done = 1'b0;
  logic       rx_par_err = 1'b0;
  logic       rx_frm_err = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick16 = 1'b0;
  logic       tx_empty_evt = 1'b0;
  logic       cpu_rbr_rd = 1'b0;
  logic       cpu_rbr_wr = 1'b0;
  logic       cpu_thr_wr = 1'b0;
  logic       cpu_lsr_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] lsr;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rx_line_status u_dut (
    .clk (clk), .rst_n (rst_n), .cfg_wlen (cfg_wlen), .cfg_par_en (cfg_par_en),
    .cfg_stop2 (cfg_stop2), .cfg_modem_mode (cfg_modem_mode),
    .rx_char_done (rx_char_done), .rx_par_err (rx_par_err), .rx_frm_err (rx_frm_err),
    .rx_line (rx_line), .tick16 (tick16), .tx_empty_evt (tx_empty_evt),
    .cpu_rbr_rd (cpu_rbr_rd), .cpu_rbr_wr (cpu_rbr_wr), .cpu_thr_wr (cpu_thr_wr),
    .cpu_lsr_rd (cpu_lsr_rd), .cpu_wdata (cpu_wdata), .lsr (lsr)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Strobes are set 1 ns after an edge, held for one edge, then dropped.
  task automatic tick_edge();
    @(posedge clk);
    #1;
    rx_char_done = 0; rx_par_err = 0; rx_frm_err = 0; tx_empty_evt = 0;
    cpu_rbr_rd = 0; cpu_rbr_wr = 0; cpu_thr_wr = 0; cpu_lsr_rd = 0; cpu_wdata = 0;
  endtask

  function automatic int bench_ticks(int w, int p, int s, int m);
    int bits;
    bits = 1 + (5 + w) + p + (1 + s);
    return bits * 16 * (m + 1);
  endfunction

  task automatic break_run(input int w, input int p, input int s, input int m);
    int thr;
    thr = bench_ticks(w, p, s, m);
    cfg_wlen = 2'(w); cfg_par_en = 1'(p); cfg_stop2 = 1'(s); cfg_modem_mode = 1'(m);
    rx_line = 0; tick16 = 1;
    repeat (thr - 1) @(posedge clk);
    #1 check(lsr & 8'h10, 8'h00, m ? "R7 break before 2 frames" : "R6 break before frame");
    @(posedge clk);
    #1 check(lsr & 8'h10, 8'h10, m ? "R7 break at 2 frames" : "R6 break at frame");
    tick16 = 0; cpu_lsr_rd = 1;
    tick_edge();
    tick16 = 1;
    repeat (thr) @(posedge clk);
    #1 check(lsr & 8'h10, 8'h00, "R6 break once per low period");
    rx_line = 1; tick16 = 0;
    tick_edge();
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(lsr, 8'h20, "R9 reset value");
    rst_n = 1;
    tick_edge();
    check(lsr, 8'h20, "R9 after reset release");

    // R1 data ready set and clear paths
    rx_char_done = 1; tick_edge();
    check(lsr, 8'h21, "R1 set on char");
    cpu_rbr_rd = 1; tick_edge();
    check(lsr, 8'h20, "R1 cleared by buffer read");
    rx_char_done = 1; tick_edge();
    cpu_rbr_wr = 1; cpu_wdata = 8'h55; tick_edge();
    check(lsr, 8'h21, "R1 nonzero write has no effect");
    cpu_rbr_wr = 1; cpu_wdata = 8'h00; tick_edge();
    check(lsr, 8'h20, "R1 zero write clears");

    // R2 overrun
    rx_char_done = 1; tick_edge();
    rx_char_done = 1; tick_edge();
    check(lsr, 8'h23, "R2 overrun on unread char");
    cpu_lsr_rd = 1; tick_edge();
    check(lsr, 8'h21, "R5 status read clears overrun, keeps data ready");
    rx_char_done = 1; cpu_rbr_rd = 1; tick_edge();
    check(lsr, 8'h21, "R2 no overrun with read in same cycle; R1 set wins");
    cpu_rbr_rd = 1; tick_edge();

    // R3 parity, R4 framing
    rx_char_done = 1; rx_par_err = 1; cpu_rbr_rd = 0; tick_edge();
    check(lsr & 8'h1E, 8'h04, "R3 parity error set");
    cpu_rbr_rd = 1; rx_char_done = 1; rx_frm_err = 1; tick_edge();
    check(lsr & 8'h1E, 8'h0C, "R4 framing error set");
    cpu_lsr_rd = 1; rx_char_done = 1; rx_par_err = 1; cpu_rbr_rd = 1; tick_edge();
    check(lsr & 8'h1E, 8'h04, "R5 same-cycle parity event wins over status read");
    cpu_lsr_rd = 1; cpu_rbr_rd = 1; tick_edge();
    check(lsr, 8'h20, "R5 all error bits clear");
    cfg_modem_mode = 1;
    rx_char_done = 1; rx_frm_err = 1; tick_edge();
    check(lsr & 8'h08, 8'h00, "R4 framing suppressed in modem mode");
    cfg_modem_mode = 0;
    cpu_rbr_rd = 1; tick_edge();

    // R8 transmit holding empty
    cpu_thr_wr = 1; tick_edge();
    check(lsr, 8'h00, "R8 cleared by holding load");
    tx_empty_evt = 1; tick_edge();
    check(lsr, 8'h20, "R8 set by empty event");
    tx_empty_evt = 1; cpu_thr_wr = 1; tick_edge();
    check(lsr, 8'h00, "R8 load wins same cycle");
    tx_empty_evt = 1; tick_edge();

    // R6 restart of count on a high cycle
    cfg_wlen = 2'd0; cfg_par_en = 0; cfg_stop2 = 0; cfg_modem_mode = 0;
    rx_line = 0; tick16 = 1;
    repeat (bench_ticks(0, 0, 0, 0) - 1) @(posedge clk);
    #1 rx_line = 1;
    @(posedge clk);
    #1 rx_line = 0;
    repeat (bench_ticks(0, 0, 0, 0) - 1) @(posedge clk);
    #1 check(lsr & 8'h10, 8'h00, "R6 high cycle restarts count");
    @(posedge clk);
    #1 check(lsr & 8'h10, 8'h10, "R6 break after restart");
    rx_line = 1; tick16 = 0; cpu_lsr_rd = 1; tick_edge();

    // R6/R7 sweep over every frame shape and both modes
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 4; w++)
        for (int p = 0; p < 2; p++)
          for (int s = 0; s < 2; s++)
            break_run(w, p, s, m);

    check(lsr & 8'hC0, 8'h00, "R9 upper bits zero");

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule